// File: doc/BRIEF.md
# Bit-Serial Carry-Save Multiplier Core

This core multiplies a multiplier that arrives one bit per clock, least significant bit first, by a parallel multiplicand that is held in redundant form as a sum vector and a carry vector. The multiplicand's value is `cand_s_i + 2*cand_c_i`. The core keeps the running partial product in the same redundant form and never resolves a carry chain. Every clock it retires one finished product bit on a serial output. It also presents the not-yet-retired upper part of the product as a sum/carry vector pair.

A one-cycle start strobe begins a new multiplication. In that cycle the stored partial product is ignored and treated as zero. On later cycles the adder network combines the registered sum/carry state with the multiplicand. The multiplicand is gated by the current multiplier bit. One half adder and two rows of full adders produce the product bit and the next state. That state drives the vector outputs directly and is registered for the following cycle. The caller resolves the upper vectors with its own carry-propagate adder when it needs them.

Top module: `bitser_cs_mul`

## Requirements
- R1: In a cycle with `load_i`=1 and `xbit_i`=1, `prod_bit_o + 2*(acc_s_o + 2*acc_c_o)` equals the multiplicand value `cand_s_i + 2*cand_c_i`.
- R2: In a cycle with `load_i`=1, the stored state has no effect. With `xbit_i`=0, all outputs (`prod_bit_o`, `acc_s_o`, `acc_c_o`) are zero, whatever the previous multiplication left behind.
- R3: Suppose `load_i` is 1 only in cycle t, the multiplicand value y is held, and bit k of x is on `xbit_i` in cycle t+k. Then in cycle t+k, `prod_bit_o + 2*(acc_s_o + 2*acc_c_o)` equals `((x mod 2^(k+1)) * y) >> k`.
- R4: In a cycle with `load_i`=0 and `xbit_i`=0, `prod_bit_o + 2*(acc_s_o + 2*acc_c_o)` equals `acc_s_o + 2*acc_c_o` of the previous cycle.
- R5: `rst` is synchronous and active high and clears the state to zero. In the first cycle after reset, with `load_i`=0 and `xbit_i`=0, all outputs are zero.
- R6: Only the multiplicand value matters. R3 holds for any split of y into `cand_s_i`/`cand_c_i`, including a split that changes from cycle to cycle.
- R7: The core works for any R >= 1. Vector ports are R+1 bits wide, and R3 holds for R=3 and for R=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start strobe; the stored partial product is taken as zero |
| xbit_i | input | 1 | Serial multiplier bit, LSB first |
| cand_s_i | input | R+1 | Multiplicand sum vector |
| cand_c_i | input | R+1 | Multiplicand carry vector (weight 2) |
| prod_bit_o | output | 1 | Retired product bit for this cycle |
| acc_s_o | output | R+1 | Upper partial product, sum vector |
| acc_c_o | output | R+1 | Upper partial product, carry vector (weight 2) |

## Verification
For R=3 the bench sweeps every multiplicand value, from zero to the largest value the two vectors can encode (all ones in both). For R=7 it uses random values. Each multiplicand is split several ways, including a split that is re-drawn every cycle, and the bench checks the weighted output against an arithmetic product every cycle. Each multiplication starts directly on top of the state left by the previous one. A core that failed to discard that state on the start strobe would therefore show a stale offset in its first result. Trailing cycles with a zero multiplier bit catch a network that misweights the carry vector or drops the top-bit adder; such a core would lose value as the state shifts down. All-ones multipliers times the maximum multiplicand drive every carry position, which exposes a row that is wired one place off.

// File: rtl/bitser_cs_mul_pkg.sv
package bitser_cs_mul_pkg;

  typedef struct packed {
    logic s;
    logic c;
  } add_res_t;

  function automatic add_res_t half_add(input logic a, input logic b);
    add_res_t r;
    r.s = a ^ b;
    r.c = a & b;
    return r;
  endfunction

  function automatic add_res_t full_add(input logic a, input logic b, input logic d);
    add_res_t r;
    r.s = a ^ b ^ d;
    r.c = (a & b) | (a & d) | (b & d);
    return r;
  endfunction

endpackage

// File: rtl/bitser_cs_state.sv
module bitser_cs_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_s_i,
  input  logic [W-1:0] nxt_c_i,
  output logic [W-1:0] st_s_o,
  output logic [W-1:0] st_c_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_s_o <= '0;
      st_c_o <= '0;
    end else begin
      st_s_o <= nxt_s_i;
      st_c_o <= nxt_c_i;
    end
  end
endmodule

// File: rtl/bitser_cs_gate.sv
module bitser_cs_gate #(
  parameter int W = 4
) (
  input  logic         load_i,
  input  logic         xbit_i,
  input  logic [W-1:0] st_s_i,
  input  logic [W-1:0] st_c_i,
  input  logic [W-1:0] cand_s_i,
  input  logic [W-1:0] cand_c_i,
  output logic [W-1:0] acc_s_o,
  output logic [W-1:0] acc_c_o,
  output logic [W-1:0] add_s_o,
  output logic [W-1:0] add_c_o
);
  always_comb begin
    acc_s_o = load_i ? '0 : st_s_i;
    acc_c_o = load_i ? '0 : st_c_i;
    add_s_o = xbit_i ? cand_s_i : '0;
    add_c_o = xbit_i ? cand_c_i : '0;
  end
endmodule

// File: rtl/bitser_cs_net.sv
module bitser_cs_net
  import bitser_cs_mul_pkg::*;
#(
  parameter int R = 3,
  localparam int W = R + 1
) (
  input  logic [W-1:0] acc_s_i,
  input  logic [W-1:0] acc_c_i,
  input  logic [W-1:0] add_s_i,
  input  logic [W-1:0] add_c_i,
  output logic         bit_o,
  output logic [W-1:0] nxt_s_o,
  output logic [W-1:0] nxt_c_o
);
  logic [R-1:0] row_s;
  logic [W-1:0] row_c;
  add_res_t     ha;
  add_res_t     top;

  always_comb begin
    ha       = half_add(acc_s_i[0], add_s_i[0]);
    bit_o    = ha.s;
    row_c[0] = ha.c;
  end

  for (genvar i = 0; i < R; i++) begin : g_row
    add_res_t r1;
    add_res_t r2;
    always_comb begin
      r1           = full_add(acc_s_i[i+1], acc_c_i[i], add_s_i[i+1]);
      row_s[i]     = r1.s;
      row_c[i+1]   = r1.c;
      r2           = full_add(add_c_i[i], row_s[i], row_c[i]);
      nxt_s_o[i]   = r2.s;
      nxt_c_o[i]   = r2.c;
    end
  end

  always_comb begin
    top        = full_add(add_c_i[R], acc_c_i[R], row_c[R]);
    nxt_s_o[R] = top.s;
    nxt_c_o[R] = top.c;
  end
endmodule

// File: rtl/bitser_cs_mul.sv
module bitser_cs_mul #(
  parameter int R = 3,
  localparam int W = R + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         xbit_i,
  input  logic [W-1:0] cand_s_i,
  input  logic [W-1:0] cand_c_i,
  output logic         prod_bit_o,
  output logic [W-1:0] acc_s_o,
  output logic [W-1:0] acc_c_o
);
  logic [W-1:0] st_s, st_c;
  logic [W-1:0] cur_s, cur_c;
  logic [W-1:0] gat_s, gat_c;
  logic [W-1:0] nxt_s, nxt_c;

  bitser_cs_state #(.W(W)) u_state (
    .clk(clk), .rst(rst),
    .nxt_s_i(nxt_s), .nxt_c_i(nxt_c),
    .st_s_o(st_s), .st_c_o(st_c)
  );

  bitser_cs_gate #(.W(W)) u_gate (
    .load_i(load_i), .xbit_i(xbit_i),
    .st_s_i(st_s), .st_c_i(st_c),
    .cand_s_i(cand_s_i), .cand_c_i(cand_c_i),
    .acc_s_o(cur_s), .acc_c_o(cur_c),
    .add_s_o(gat_s), .add_c_o(gat_c)
  );

  bitser_cs_net #(.R(R)) u_net (
    .acc_s_i(cur_s), .acc_c_i(cur_c),
    .add_s_i(gat_s), .add_c_i(gat_c),
    .bit_o(prod_bit_o),
    .nxt_s_o(nxt_s), .nxt_c_o(nxt_c)
  );

  assign acc_s_o = nxt_s;
  assign acc_c_o = nxt_c;
endmodule

// File: rtl/bitser_cs_mul_chk.sv
module bitser_cs_mul_chk #(
  parameter int R = 3,
  localparam int W = R + 1,
  localparam int VW = W + 3
) (
  input logic         clk,
  input logic         rst,
  input logic         load_i,
  input logic         xbit_i,
  input logic [W-1:0] cand_s_i,
  input logic [W-1:0] cand_c_i,
  input logic         prod_bit_o,
  input logic [W-1:0] acc_s_o,
  input logic [W-1:0] acc_c_o
);
  logic [VW-1:0] out_val, cand_val, upper_val, prev_upper;
  logic          armed;

  always_comb begin
    out_val   = VW'(prod_bit_o) + (VW'(acc_s_o) << 1) + (VW'(acc_c_o) << 2);
    cand_val  = VW'(cand_s_i) + (VW'(cand_c_i) << 1);
    upper_val = VW'(acc_s_o) + (VW'(acc_c_o) << 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      prev_upper <= '0;
    end else begin
      armed      <= 1'b1;
      prev_upper <= upper_val;
    end
  end

  // R1
  load_mult_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && xbit_i) |-> (out_val == cand_val));

  // R2
  load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !xbit_i) |-> (!prod_bit_o && acc_s_o == '0 && acc_c_o == '0));

  // R4
  idle_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !load_i && !xbit_i) |-> (out_val == prev_upper));

  // R5
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !load_i && !xbit_i) |-> (out_val == '0));
endmodule

bind bitser_cs_mul bitser_cs_mul_chk #(.R(R)) u_chk (.*);

// File: tb/tb_bitser_cs_mul.sv
module tb_bitser_cs_mul;
  localparam int RA = 7, WA = RA + 1, MA = (1 << WA) - 1;
  localparam int RB = 3, WB = RB + 1, MB = (1 << WB) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic load = 1'b0, xb = 1'b0;
  logic [WA-1:0] sa, ca, zsa, zca;
  logic [WB-1:0] sb, cb, zsb, zcb;
  logic zba, zbb;
  int checks = 0, errors = 0;
  longint preva, prevb;

  always #4 clk = ~clk;

  bitser_cs_mul #(.R(RA)) dut (
    .clk(clk), .rst(rst), .load_i(load), .xbit_i(xb),
    .cand_s_i(sa), .cand_c_i(ca),
    .prod_bit_o(zba), .acc_s_o(zsa), .acc_c_o(zca));

  bitser_cs_mul #(.R(RB)) dut_r3 (
    .clk(clk), .rst(rst), .load_i(load), .xbit_i(xb),
    .cand_s_i(sb), .cand_c_i(cb),
    .prod_bit_o(zbb), .acc_s_o(zsb), .acc_c_o(zcb));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic split(input int y, input int m, output int s, output int c);
    int lo, hi;
    hi = (y / 2 < m) ? y / 2 : m;
    lo = (y > m) ? (y - m + 1) / 2 : 0;
    c  = lo + int'($urandom % (hi - lo + 1));
    s  = y - 2 * c;
  endtask

  // One multiplication on both cores; x bits past 15 are zero (idle tail).
  task automatic run_case(input longint x, input int ya, input int yb, input bit vary);
    int s, c;
    longint va, vb, ea, eb;
    string tg;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      load = (k == 0);
      xb   = x[k];
      if (k == 0 || vary) begin
        split(ya, MA, s, c); sa = WA'(s); ca = WA'(c);
        split(yb, MB, s, c); sb = WB'(s); cb = WB'(c);
      end
      #2;
      va = longint'(zba) + 2 * (longint'(zsa) + 2 * longint'(zca));
      vb = longint'(zbb) + 2 * (longint'(zsb) + 2 * longint'(zcb));
      ea = ((x & ((64'd1 << (k + 1)) - 1)) * ya) >> k;
      eb = ((x & ((64'd1 << (k + 1)) - 1)) * yb) >> k;
      if (k == 0) tg = xb ? "R1" : "R2";
      else tg = vary ? "R6 R3" : "R3";
      check({tg, " R7 r=7"}, va, ea);
      check({tg, " R7 r=3"}, vb, eb);
      if (k > 0 && !xb) begin
        check("R4 r=7", va, preva);
        check("R4 r=3", vb, prevb);
      end
      preva = longint'(zsa) + 2 * longint'(zca);
      prevb = longint'(zsb) + 2 * longint'(zcb);
    end
  endtask

  initial begin
    sa = '0; ca = '0; sb = '0; cb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R5 r=7", longint'(zba) + 2 * (longint'(zsa) + 2 * longint'(zca)), 0);
    check("R5 r=3", longint'(zbb) + 2 * (longint'(zsb) + 2 * longint'(zcb)), 0);
    run_case(64'hFFFF, 3 * MA, 3 * MB, 1'b0);
    run_case(64'h0000, 3 * MA, 3 * MB, 1'b0);
    run_case(64'hA5A4, 3 * MA, 3 * MB, 1'b1);
    for (int y = 0; y <= 3 * MB; y++) begin
      run_case(longint'($urandom & 16'hFFFF), int'($urandom % (3 * MA + 1)), y, 1'b0);
      run_case(longint'($urandom & 16'hFFFF), int'($urandom % (3 * MA + 1)), y, 1'b1);
    end
    // restart right on top of a non-zero state with multiplier bit 0
    run_case(64'hFFFE, 3 * MA, 3 * MB, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule